// File: doc/BRIEF.md
# Protocol discovery responder

This block sits behind a data-object mailbox and answers discovery queries on its own. Request objects arrive one 32-bit dword per cycle, with a marker on the final dword. If the first dword names the discovery protocol, the block consumes the object. It checks the length dword and takes the requested index from the third dword. It then returns a three-dword response object. That response states which protocol sits at the requested index and which index to ask for next. Any object whose first dword names another protocol is passed on unchanged to a secondary port, where the rest of the endpoint handles it.

The list of supported protocols is fixed at build time. Entry 0 is always the discovery protocol itself. The remaining entries come from two packed parameter vectors, one holding vendor IDs and one holding protocol types. A requester learns the whole list by starting at index 0 and following the next-index values until it reads a next index of zero. Malformed discovery requests and out-of-range indices raise a one-cycle error pulse and produce no response.

Top module: `disc_responder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `rsp_valid`, `fwd_valid` and `err` are 0.
- R2: A discovery object has three dwords. The first dword has vendor ID `DISC_VID` in bits 15:0 and type 0 in bits 23:16. When its third dword (marked last) is accepted at clock edge k, the three response dwords are presented after edges k+1, k+2 and k+3, with `rsp_valid` high on exactly those cycles.
- R3: Response dword 0 is `{16'h0000, DISC_VID}`. Dword 1 is the length 3. `rsp_last` is high only with dword 2.
- R4: Response dword 2 carries the vendor ID (bits 15:0) and type (bits 23:16) of the entry at the requested index. Entry 0 is the discovery protocol itself, and entry i ≥ 1 is slice i-1 of `EXTRA_VID` and `EXTRA_TYPE`.
- R5: Bits 31:24 of response dword 2 are the requested index plus one, or 0 when the requested index is the last entry (`NUM_EXTRA`).
- R6: An index (bits 7:0 of the third request dword) greater than `NUM_EXTRA` pulses `err` for one cycle, after the edge that accepted that dword, and yields no response.
- R7: A discovery object is malformed when any of these holds: its length field (bits 17:0 of dword 1, higher bits ignored) is not 3; it ends before three dwords; or it continues past three dwords. A malformed object pulses `err` once, at the offending dword. It yields no response, and its remaining dwords are dropped.
- R8: An object whose first dword does not match the discovery header is presented on `fwd_data`/`fwd_last` with `fwd_valid`, dword for dword, one cycle after each accepted input dword.
- R9: Input dwords accepted at edges k+1, k+2 and k+3 after a discovery request ends at edge k are ignored. From edge k+4 on, input is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request dword present |
| in_data | input | 32 | Request dword |
| in_last | input | 1 | Final dword of the request object |
| rsp_valid | output | 1 | Response dword present |
| rsp_data | output | 32 | Response dword |
| rsp_last | output | 1 | Final response dword |
| fwd_valid | output | 1 | Forwarded dword present |
| fwd_data | output | 32 | Forwarded dword of a non-discovery object |
| fwd_last | output | 1 | Final forwarded dword |
| err | output | 1 | One-cycle pulse on a rejected discovery request |

## Verification
The bench builds the block with `NUM_EXTRA` = 3, giving a four-entry list in which two of the added entries share a vendor ID and differ only in type. This size lets the bench walk the whole chain to its zero terminator. It also lets it probe index 4, the first one past the end, as well as index 255. Headers that carry the discovery vendor ID with a non-zero type, or type 0 under a different vendor ID, check that both header fields are needed for a match. Requests placed inside the ignore window after a query check that only that window is dropped.

// File: rtl/disc_resp_pkg.sv
package disc_resp_pkg;

    localparam int DW    = 32;
    localparam int LEN_W = 18;
    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        PS_HDR,
        PS_LEN,
        PS_IDX,
        PS_FWD,
        PS_DRAIN
    } parse_st_e;

endpackage

// File: rtl/disc_table.sv
module disc_table
    import disc_resp_pkg::*;
#(
    parameter logic [15:0]             DISC_VID   = 16'h0001,
    parameter int                      NUM_EXTRA  = 2,
    parameter logic [NUM_EXTRA*16-1:0] EXTRA_VID  = {NUM_EXTRA{16'h1A2B}},
    parameter logic [NUM_EXTRA*8-1:0]  EXTRA_TYPE = {NUM_EXTRA{8'h01}}
) (
    input  logic [IDX_W-1:0] idx,
    output logic [DW-1:0]    word
);

    localparam int NUM_ENT = NUM_EXTRA + 1;

    logic [15:0] vid_a [NUM_ENT];
    logic [7:0]  typ_a [NUM_ENT];

    assign vid_a[0] = DISC_VID;
    assign typ_a[0] = 8'h00;

    for (genvar g = 1; g < NUM_ENT; g++) begin : g_ent
        assign vid_a[g] = EXTRA_VID[(g-1)*16 +: 16];
        assign typ_a[g] = EXTRA_TYPE[(g-1)*8 +: 8];
    end

    logic [15:0]      sel_vid;
    logic [7:0]       sel_typ;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        sel_vid = '0;
        sel_typ = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_vid = vid_a[i];
                sel_typ = typ_a[i];
            end
        end
        nxt  = (idx == IDX_W'(NUM_ENT - 1)) ? '0 : idx + IDX_W'(1);
        word = {nxt, sel_typ, sel_vid};
    end

endmodule

// File: rtl/disc_req_parser.sv
module disc_req_parser
    import disc_resp_pkg::*;
#(
    parameter logic [15:0] DISC_VID = 16'h0001,
    parameter int          NUM_ENT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             in_last,
    input  logic             busy,
    output logic             go,
    output logic [IDX_W-1:0] go_idx,
    output logic             err,
    output logic             fwd_valid,
    output logic [DW-1:0]    fwd_data,
    output logic             fwd_last
);

    typedef struct packed {
        parse_st_e        st;
        logic             go;
        logic [IDX_W-1:0] idx;
        logic             err;
        logic             fv;
        logic [DW-1:0]    fd;
        logic             fl;
    } parse_t;

    parse_t par_d, par_q;

    logic is_disc;
    logic len_ok;
    logic idx_ok;

    assign is_disc = (in_data[15:0] == DISC_VID) && (in_data[23:16] == 8'h00);
    assign len_ok  = (in_data[LEN_W-1:0] == LEN_W'(3));
    assign idx_ok  = (int'(in_data[IDX_W-1:0]) < NUM_ENT);

    always_comb begin
        par_d     = par_q;
        par_d.go  = 1'b0;
        par_d.err = 1'b0;
        par_d.fv  = 1'b0;
        if (in_valid && !busy) begin
            unique case (par_q.st)
                PS_HDR: begin
                    if (is_disc) begin
                        if (in_last) par_d.err = 1'b1;
                        else         par_d.st  = PS_LEN;
                    end else begin
                        par_d.fv = 1'b1;
                        par_d.fd = in_data;
                        par_d.fl = in_last;
                        if (!in_last) par_d.st = PS_FWD;
                    end
                end
                PS_LEN: begin
                    if (in_last) begin
                        par_d.err = 1'b1;
                        par_d.st  = PS_HDR;
                    end else if (!len_ok) begin
                        par_d.err = 1'b1;
                        par_d.st  = PS_DRAIN;
                    end else begin
                        par_d.st  = PS_IDX;
                    end
                end
                PS_IDX: begin
                    par_d.st = in_last ? PS_HDR : PS_DRAIN;
                    if (!in_last || !idx_ok) begin
                        par_d.err = 1'b1;
                    end else begin
                        par_d.go  = 1'b1;
                        par_d.idx = in_data[IDX_W-1:0];
                    end
                end
                PS_FWD: begin
                    par_d.fv = 1'b1;
                    par_d.fd = in_data;
                    par_d.fl = in_last;
                    if (in_last) par_d.st = PS_HDR;
                end
                PS_DRAIN: begin
                    if (in_last) par_d.st = PS_HDR;
                end
                default: par_d.st = PS_HDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '{st: PS_HDR, go: 1'b0, idx: '0, err: 1'b0,
                       fv: 1'b0, fd: '0, fl: 1'b0};
        end else begin
            par_q <= par_d;
        end
    end

    assign go        = par_q.go;
    assign go_idx    = par_q.idx;
    assign err       = par_q.err;
    assign fwd_valid = par_q.fv;
    assign fwd_data  = par_q.fd;
    assign fwd_last  = par_q.fl;

endmodule

// File: rtl/disc_rsp_tx.sv
module disc_rsp_tx
    import disc_resp_pkg::*;
#(
    parameter logic [15:0] DISC_VID = 16'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [IDX_W-1:0] go_idx,
    input  logic [DW-1:0]    ent_word,
    output logic [IDX_W-1:0] cur_idx,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_last
);

    typedef struct packed {
        logic             act;
        logic [1:0]       beat;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    data;
        logic             last;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (go) begin
            tx_d.act  = 1'b1;
            tx_d.beat = 2'd0;
            tx_d.idx  = go_idx;
            tx_d.data = {16'h0000, DISC_VID};
            tx_d.last = 1'b0;
        end else if (tx_q.act) begin
            unique case (tx_q.beat)
                2'd0: begin
                    tx_d.beat = 2'd1;
                    tx_d.data = DW'(3);
                end
                2'd1: begin
                    tx_d.beat = 2'd2;
                    tx_d.data = ent_word;
                    tx_d.last = 1'b1;
                end
                default: begin
                    tx_d.act  = 1'b0;
                    tx_d.beat = 2'd0;
                    tx_d.data = '0;
                    tx_d.last = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign cur_idx   = tx_q.idx;
    assign rsp_valid = tx_q.act;
    assign rsp_data  = tx_q.data;
    assign rsp_last  = tx_q.last;

endmodule

// File: rtl/disc_responder.sv
module disc_responder
    import disc_resp_pkg::*;
#(
    parameter logic [15:0]             DISC_VID   = 16'h0001,
    parameter int                      NUM_EXTRA  = 2,
    parameter logic [NUM_EXTRA*16-1:0] EXTRA_VID  = {16'h1A2B, 16'h1A2B},
    parameter logic [NUM_EXTRA*8-1:0]  EXTRA_TYPE = {8'h02, 8'h01}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    output logic          rsp_valid,
    output logic [31:0]   rsp_data,
    output logic          rsp_last,
    output logic          fwd_valid,
    output logic [31:0]   fwd_data,
    output logic          fwd_last,
    output logic          err
);

    localparam int NUM_ENT = NUM_EXTRA + 1;

    logic             go;
    logic [IDX_W-1:0] go_idx;
    logic [IDX_W-1:0] cur_idx;
    logic [DW-1:0]    ent_word;
    logic             busy;

    assign busy = go | (rsp_valid & ~rsp_last);

    disc_req_parser #(
        .DISC_VID (DISC_VID),
        .NUM_ENT  (NUM_ENT)
    ) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .busy      (busy),
        .go        (go),
        .go_idx    (go_idx),
        .err       (err),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .fwd_last  (fwd_last)
    );

    disc_table #(
        .DISC_VID   (DISC_VID),
        .NUM_EXTRA  (NUM_EXTRA),
        .EXTRA_VID  (EXTRA_VID),
        .EXTRA_TYPE (EXTRA_TYPE)
    ) u_tab (
        .idx  (cur_idx),
        .word (ent_word)
    );

    disc_rsp_tx #(
        .DISC_VID (DISC_VID)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_idx    (go_idx),
        .ent_word  (ent_word),
        .cur_idx   (cur_idx),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

endmodule

// File: rtl/disc_responder_chk.sv
module disc_responder_chk #(
    parameter logic [15:0] DISC_VID = 16'h0001,
    parameter int          NUM_ENT  = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        rsp_last,
    input logic        fwd_valid,
    input logic        err
);

    // R3: the last marker only travels with a valid dword
    a_r3_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> rsp_valid);

    // R3: a response runs without gaps until its last dword
    a_r3_contig: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_last |=> rsp_valid);

    // R3: first dword of every response is the discovery header
    a_r3_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> rsp_data == {16'h0000, DISC_VID});

    // R3: middle dword carries length 3
    a_r3_len: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(rsp_valid) && !rsp_last |-> rsp_data == 32'd3);

    // R2: response is exactly three dwords long
    a_r2_three: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> !rsp_valid);

    // R5: next index never points past the list
    a_r5_next: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> int'(rsp_data[31:24]) < NUM_ENT);

    // R6: an error is never followed by a response dword
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !rsp_valid);

    // R9: input is ignored while the response is in flight
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !fwd_valid && !err);

    // R8: forwarded dwords only follow accepted input
    a_r8_src: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(in_valid));

endmodule

bind disc_responder disc_responder_chk #(
    .DISC_VID (DISC_VID),
    .NUM_ENT  (NUM_EXTRA + 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .fwd_valid (fwd_valid),
    .err       (err)
);

// File: tb/sim_disc_responder.sv
`timescale 1ns/1ps
module sim_disc_responder;

    localparam logic [15:0] DVID = 16'h0001;
    localparam int          NX   = 3;
    localparam int          NENT = NX + 1;
    localparam logic [NX*16-1:0] XVID = {16'h1A2B, 16'h3C4D, 16'h1A2B};
    localparam logic [NX*8-1:0]  XTYP = {8'h07, 8'h11, 8'h05};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        rsp_valid, rsp_last, fwd_valid, fwd_last, err;
    logic [31:0] rsp_data, fwd_data;

    always #4 clk = ~clk;

    disc_responder #(
        .DISC_VID   (DVID),
        .NUM_EXTRA  (NX),
        .EXTRA_VID  (XVID),
        .EXTRA_TYPE (XTYP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data),
        .fwd_last  (fwd_last),
        .err       (err)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    cyc     = 0;
    bit    done    = 1'b0;
    string scen    = "R1 reset";

    // reference list: entry 0 is discovery, then the added entries
    logic [15:0] bvid [NENT] = '{16'h0001, 16'h1A2B, 16'h3C4D, 16'h1A2B};
    logic [7:0]  btyp [NENT] = '{8'h00, 8'h05, 8'h11, 8'h07};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, scen, act, exp);
        end
    endtask

    // behavioural reference model
    logic [32:0] rq [$];
    int          pos  = 0;
    bit          disc = 1'b0;
    bit          dead = 1'b0;
    logic        e_rv = 1'b0, e_rl = 1'b0, e_fv = 1'b0, e_fl = 1'b0, e_err = 1'b0;
    logic [31:0] e_rd = '0, e_fd = '0;

    always @(posedge clk) begin
        bit          busy;
        logic [32:0] w;
        int          ix;
        int          nx;
        if (!rst_n) begin
            rq.delete();
            pos = 0; disc = 1'b0; dead = 1'b0;
            e_rv = 1'b0; e_rl = 1'b0; e_fv = 1'b0; e_fl = 1'b0; e_err = 1'b0;
        end else begin
            e_err = 1'b0; e_fv = 1'b0; e_rv = 1'b0; e_rl = 1'b0;
            busy = (rq.size() > 0);
            if (busy) begin
                w = rq.pop_front();
                e_rv = 1'b1; e_rd = w[31:0]; e_rl = w[32];
            end
            if (in_valid && !busy) begin
                if (pos == 0) disc = (in_data[15:0] == DVID) && (in_data[23:16] == 8'h00);
                if (!disc) begin
                    e_fv = 1'b1; e_fd = in_data; e_fl = in_last;
                end else if (!dead) begin
                    if (pos == 0 && in_last) begin
                        e_err = 1'b1;
                    end else if (pos == 1 && (in_last || in_data[17:0] != 18'd3)) begin
                        e_err = 1'b1; dead = 1'b1;
                    end else if (pos == 2) begin
                        ix = int'(in_data[7:0]);
                        if (!in_last || ix >= NENT) begin
                            e_err = 1'b1;
                        end else begin
                            nx = (ix == NENT - 1) ? 0 : ix + 1;
                            rq.push_back({1'b0, 16'h0000, DVID});
                            rq.push_back({1'b0, 32'd3});
                            rq.push_back({1'b1, 8'(nx), btyp[ix], bvid[ix]});
                        end
                        dead = 1'b1;
                    end
                end
                if (in_last) begin pos = 0; dead = 1'b0; end
                else pos++;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rsp_valid", 32'(rsp_valid), 32'(e_rv));
            if (e_rv) begin
                chk("R4 rsp_data", rsp_data, e_rd);
                chk("R3 rsp_last", 32'(rsp_last), 32'(e_rl));
            end
            chk("R8 fwd_valid", 32'(fwd_valid), 32'(e_fv));
            if (e_fv) begin
                chk("R8 fwd_data", fwd_data, e_fd);
                chk("R8 fwd_last", 32'(fwd_last), 32'(e_fl));
            end
            chk("R6 err", 32'(err), 32'(e_err));
        end
    end

    task automatic put(input logic [31:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_data = '0; in_last = 1'b0;
        end
    endtask

    task automatic query(input logic [7:0] ix);
        put({16'h0000, DVID}, 1'b0);
        put(32'd3, 1'b0);
        put({24'h0, ix}, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog [%s] actual=%0d expected=%0d", scen, cyc, 20000);
            finish_run();
        end
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 fwd_valid", 32'(fwd_valid), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        rst_n = 1'b1;
        gap(2);

        scen = "R4 entry zero is discovery";
        query(8'd0); gap(6);

        scen = "R5 chain walk to terminator";
        query(8'd1); gap(5);
        query(8'd2); gap(5);
        query(8'd3); gap(6);

        scen = "R6 index just past end";
        query(8'd4); gap(3);
        scen = "R6 index 255";
        query(8'hFF); gap(3);

        scen = "R7 length field 4";
        put({16'h0000, DVID}, 1'b0); put(32'd4, 1'b0); put(32'd1, 1'b1); gap(3);
        scen = "R7 ends after length";
        put({16'h0000, DVID}, 1'b0); put(32'd3, 1'b1); gap(3);
        scen = "R7 header only";
        put({16'h0000, DVID}, 1'b1); gap(3);
        scen = "R7 four dwords";
        put({16'h0000, DVID}, 1'b0); put(32'd3, 1'b0); put(32'd1, 1'b0); put(32'hDEAD0001, 1'b1); gap(4);
        scen = "R7 upper length bits ignored";
        put({16'h0000, DVID}, 1'b0); put(32'hFFFC0003, 1'b0); put(32'd2, 1'b1); gap(6);

        scen = "R8 vendor object forwarded";
        put(32'h00051A2B, 1'b0); put(32'd5, 1'b0); put(32'h11112222, 1'b0);
        put(32'h33334444, 1'b0); put(32'h55556666, 1'b1); gap(3);
        scen = "R8 discovery vid with type 1";
        put({16'h0001, DVID}, 1'b0); put(32'd3, 1'b0); put(32'd0, 1'b1); gap(3);
        scen = "R8 type 0 other vid";
        put(32'h00001A2B, 1'b1); gap(3);

        scen = "R9 object during busy window";
        query(8'd1);
        put(32'h00091A2B, 1'b0); put(32'hA5A5A5A5, 1'b0); put(32'h5A5A5A5A, 1'b1);
        put(32'h00091A2B, 1'b1); gap(4);
        scen = "R9 query straight after response";
        query(8'd2);
        put(32'h00071A2B, 1'b0); put(32'h0, 1'b0); put(32'h1, 1'b1);
        query(8'd3); gap(6);

        scen = "R2 back to back forward then query";
        put(32'h00021A2B, 1'b1);
        query(8'd0); gap(6);

        finish_run();
    end

endmodule